// File: doc/BRIEF.md
# Key Event Queue with Indexed Peek

This block holds keypad events in a circular queue of sixteen byte-wide slots. A scanner upstream offers one event per cycle as a 7-bit key code and a press flag; the block packs them into one byte, with the flag in the top bit, and appends it behind the entries already held. A status and error register block sits beside it. It receives one-cycle requests to set its keypad interrupt bit and its queue overflow error bit, and it feeds back the current overflow error and error status bits. While both are set, the queue takes no new events.

Two read paths serve the host. The consuming read treats the slot under the start pointer as already delivered: it moves the start pointer one slot forward, shortens the queue by one and returns the byte in the new start slot on `pop_data` in the cycle after the request. When one entry or none is held it returns zero and changes nothing. The peek path is combinational. It returns the byte at any offset from the start pointer, or zero when the offset is not below the current length, and it never moves a pointer. A flush request, raised when the configuration is rewritten, empties the queue by zeroing both pointer and length. It leaves the slot contents as they are.

An occupancy state machine runs beside the length counter. Its states are EMPTY (no entry), SINGLE (one entry, nothing consumable), SOME (two to fifteen entries) and FULL (sixteen). The transitions are: GROW on an accepted append with no consuming read; SHRINK on a consuming read with no append; SWAP when both happen together, which keeps the state; and CLEAR on flush, which leads from any state to EMPTY.

Top module: `key_event_queue`

## Requirements
- R1: After reset the length is 0, `pop_data` is 0x00 and neither set request is raised.
- R2: An accepted event is stored as one byte, with the key code in bits 6:0 and the press flag in bit 7, in the slot at start plus length modulo 16.
- R3: Each accepted event adds one to the length and raises `kpd_int_set` for exactly one cycle, one clock after the append.
- R4: An event offered while 16 entries are held is dropped. The length stays at 16 and `fifo_ovf_set` pulses for one cycle, one clock later, asking for error bit 6 and the error status bit to be set.
- R5: While `err_ovf_bit` and `err_status_bit` are both 1, offered events are ignored: no length change and neither set request. With only one of the two set, events are handled as usual.
- R6: A consuming read while the length is 0 or 1 puts 0x00 on `pop_data` on the next clock and leaves the length and start pointer unchanged.
- R7: A consuming read while the length is 2 or more advances the start pointer by one modulo 16, takes one from the length, and puts the byte in the new start slot on `pop_data` on the next clock. `pop_data` holds its value in cycles with no read and no flush.
- R8: `peek_data` for offset i is the byte at start plus i modulo 16 when i is below the length, and 0x00 otherwise. Peeking never changes the queue.
- R9: The pointers wrap modulo 16, so events come out in arrival order across any number of passes around the storage.
- R10: A flush sets the start pointer and the length to 0, clears `pop_data` on the next clock and takes priority over an append or a read in the same cycle. Stored bytes are not erased, but peeks beyond the new length return 0x00.
- R11: When an append and a consuming read are both accepted in one cycle, the length is unchanged and the new byte is written at the start pointer plus length taken before the read. A read with 16 entries held still consumes, while the simultaneous append is dropped as an overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid | input | 1 | An event is offered this cycle |
| push_code | input | 7 | Key code of the offered event |
| push_press | input | 1 | 1 for press, 0 for release |
| pop_req | input | 1 | Consuming read request |
| flush | input | 1 | Empty the queue |
| err_ovf_bit | input | 1 | Current overflow error bit from the register block |
| err_status_bit | input | 1 | Current error status bit from the register block |
| peek_idx | input | 4 | Peek offset from the start pointer |
| peek_data | output | 8 | Peeked byte, combinational |
| pop_data | output | 8 | Byte returned by the last consuming read |
| len_o | output | 5 | Number of entries held |
| kpd_int_set | output | 1 | One-cycle request to set the keypad interrupt bit |
| fifo_ovf_set | output | 1 | One-cycle request to set the overflow error bit and the error status bit |

## Verification
The bench targets the off-by-one behaviour of the consuming read. The first event appended to an empty queue can only be seen by peek, and a design that fetched before advancing would return it, pushing every later byte one place out of order. It fills the queue to sixteen and offers more, so a design that accepted a seventeenth entry, or raised the keypad request on a drop, is caught in the length and pulse comparisons. It offers events with only one of the two lock inputs set and with both set, and it issues an append together with a read at lengths 1, middle and 16: a design that reused the post-read start, or dropped the append when reading from a full queue, would show it in the peeked slots. Long mixed runs carry the pointers around the storage several times, and flushes land together with appends and reads to show that flush takes priority.

// File: rtl/kq_pkg.sv
package kq_pkg;

    // Occupancy class of the queue, tracked beside the length counter
    typedef enum logic [1:0] {
        OCC_EMPTY  = 2'd0,
        OCC_SINGLE = 2'd1,
        OCC_SOME   = 2'd2,
        OCC_FULL   = 2'd3
    } occ_e;

    // Transition taken by the occupancy machine in a cycle
    typedef enum logic [2:0] {
        EV_IDLE   = 3'd0,
        EV_GROW   = 3'd1,
        EV_SHRINK = 3'd2,
        EV_SWAP   = 3'd3,
        EV_CLEAR  = 3'd4
    } occ_ev_e;

endpackage

// File: rtl/kq_store.sv
module kq_store #(
    parameter int DEPTH   = 16,
    parameter int ENTRY_W = 8,
    localparam int PTR_W  = $clog2(DEPTH)
) (
    input  logic               clk,
    input  logic               wr_en,
    input  logic [PTR_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [PTR_W-1:0]   rd_addr_a,
    output logic [ENTRY_W-1:0] rd_data_a,
    input  logic [PTR_W-1:0]   rd_addr_b,
    output logic [ENTRY_W-1:0] rd_data_b
);

    logic [ENTRY_W-1:0] slot_q [DEPTH];

    // One register per slot, written only when addressed; never cleared
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_addr == PTR_W'(g))) begin
                slot_q[g] <= wr_data;
            end
        end
    end

    assign rd_data_a = slot_q[rd_addr_a];
    assign rd_data_b = slot_q[rd_addr_b];

endmodule

// File: rtl/kq_ctrl.sv
module kq_ctrl
    import kq_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LEN_W = PTR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_valid,
    input  logic             pop_req,
    input  logic             flush,
    input  logic             lock,
    output logic             push_ok,
    output logic             push_drop,
    output logic             pop_ok,
    output logic [PTR_W-1:0] wr_addr,
    output logic [PTR_W-1:0] pop_addr,
    output logic [PTR_W-1:0] start_o,
    output logic [LEN_W-1:0] len_o,
    output occ_e             occ_o
);

    localparam logic [LEN_W-1:0] LEN_FULL = LEN_W'(DEPTH);
    localparam logic [LEN_W-1:0] LEN_ONE  = LEN_W'(1);
    localparam logic [LEN_W-1:0] LEN_TWO  = LEN_W'(2);
    localparam logic [LEN_W-1:0] LEN_NEAR = LEN_W'(DEPTH - 1);

    occ_e             occ_q, occ_d;
    occ_ev_e          ev;
    logic [PTR_W-1:0] start_q, start_d;
    logic [LEN_W-1:0] len_q, len_d;
    logic             offer;

    // Acceptance decisions use the length held before this cycle's read
    assign offer     = push_valid && !flush && !lock;
    assign push_ok   = offer && (len_q != LEN_FULL);
    assign push_drop = offer && (len_q == LEN_FULL);
    assign pop_ok    = pop_req && !flush && (len_q > LEN_ONE);

    assign wr_addr  = start_q + len_q[PTR_W-1:0];
    assign pop_addr = start_q + PTR_W'(1);

    // Name the transition of this cycle
    always_comb begin
        if (flush) begin
            ev = EV_CLEAR;
        end else if (push_ok && pop_ok) begin
            ev = EV_SWAP;
        end else if (push_ok) begin
            ev = EV_GROW;
        end else if (pop_ok) begin
            ev = EV_SHRINK;
        end else begin
            ev = EV_IDLE;
        end
    end

    // Pointer and length update
    always_comb begin
        start_d = start_q;
        len_d   = len_q;
        unique case (ev)
            EV_CLEAR: begin
                start_d = '0;
                len_d   = '0;
            end
            EV_GROW:   len_d = len_q + LEN_W'(1);
            EV_SHRINK: begin
                start_d = pop_addr;
                len_d   = len_q - LEN_W'(1);
            end
            EV_SWAP:   start_d = pop_addr;
            EV_IDLE:   ;
            default:   ;
        endcase
    end

    // Occupancy machine: next state
    always_comb begin
        occ_d = occ_q;
        unique case (occ_q)
            OCC_EMPTY: begin
                if (ev == EV_GROW) occ_d = OCC_SINGLE;
            end
            OCC_SINGLE: begin
                if (ev == EV_CLEAR)     occ_d = OCC_EMPTY;
                else if (ev == EV_GROW) occ_d = OCC_SOME;
            end
            OCC_SOME: begin
                if (ev == EV_CLEAR) begin
                    occ_d = OCC_EMPTY;
                end else if (ev == EV_GROW && len_q == LEN_NEAR) begin
                    occ_d = OCC_FULL;
                end else if (ev == EV_SHRINK && len_q == LEN_TWO) begin
                    occ_d = OCC_SINGLE;
                end
            end
            OCC_FULL: begin
                if (ev == EV_CLEAR) begin
                    occ_d = OCC_EMPTY;
                end else if (ev == EV_SHRINK) begin
                    occ_d = (DEPTH > 2) ? OCC_SOME : OCC_SINGLE;
                end
            end
            default: occ_d = OCC_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ_q   <= OCC_EMPTY;
            start_q <= '0;
            len_q   <= '0;
        end else begin
            occ_q   <= occ_d;
            start_q <= start_d;
            len_q   <= len_d;
        end
    end

    assign start_o = start_q;
    assign len_o   = len_q;
    assign occ_o   = occ_q;

endmodule

// File: rtl/key_event_queue.sv
module key_event_queue
    import kq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int CODE_W  = 7,
    localparam int ENTRY_W = CODE_W + 1,
    localparam int PTR_W   = $clog2(DEPTH),
    localparam int LEN_W   = PTR_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push_valid,
    input  logic [CODE_W-1:0]  push_code,
    input  logic               push_press,
    input  logic               pop_req,
    input  logic               flush,
    input  logic               err_ovf_bit,
    input  logic               err_status_bit,
    input  logic [PTR_W-1:0]   peek_idx,
    output logic [ENTRY_W-1:0] peek_data,
    output logic [ENTRY_W-1:0] pop_data,
    output logic [LEN_W-1:0]   len_o,
    output logic               kpd_int_set,
    output logic               fifo_ovf_set
);

    logic               push_ok, push_drop, pop_ok;
    logic [PTR_W-1:0]   wr_addr, pop_addr, start_q;
    logic [ENTRY_W-1:0] pop_word, peek_word;
    logic [ENTRY_W-1:0] pop_data_q;
    logic               kpd_q, ovf_q;
    occ_e               occ;

    kq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .pop_req    (pop_req),
        .flush      (flush),
        .lock       (err_ovf_bit && err_status_bit),
        .push_ok    (push_ok),
        .push_drop  (push_drop),
        .pop_ok     (pop_ok),
        .wr_addr    (wr_addr),
        .pop_addr   (pop_addr),
        .start_o    (start_q),
        .len_o      (len_o),
        .occ_o      (occ)
    );

    kq_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) u_store (
        .clk       (clk),
        .wr_en     (push_ok),
        .wr_addr   (wr_addr),
        .wr_data   ({push_press, push_code}),
        .rd_addr_a (pop_addr),
        .rd_data_a (pop_word),
        .rd_addr_b (start_q + peek_idx),
        .rd_data_b (peek_word)
    );

    // Output process: read data and one-cycle set requests
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pop_data_q <= '0;
            kpd_q      <= 1'b0;
            ovf_q      <= 1'b0;
        end else begin
            kpd_q <= push_ok;
            ovf_q <= push_drop;
            if (flush) begin
                pop_data_q <= '0;
            end else if (pop_req) begin
                pop_data_q <= pop_ok ? pop_word : '0;
            end
        end
    end

    assign peek_data    = (LEN_W'(peek_idx) < len_o) ? peek_word : '0;
    assign pop_data     = pop_data_q;
    assign kpd_int_set  = kpd_q;
    assign fifo_ovf_set = ovf_q;

endmodule

// File: rtl/key_event_queue_chk.sv
module key_event_queue_chk
    import kq_pkg::*;
#(
    parameter int DEPTH  = 16,
    localparam int LEN_W = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             push_valid,
    input logic             pop_req,
    input logic             flush,
    input logic             err_ovf_bit,
    input logic             err_status_bit,
    input logic [7:0]       pop_data,
    input logic [LEN_W-1:0] len_o,
    input logic             kpd_int_set,
    input logic             fifo_ovf_set,
    input occ_e             occ
);

    localparam logic [LEN_W-1:0] LFULL = LEN_W'(DEPTH);

    AST_LEN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        len_o <= LFULL); // R4

    AST_KPD_FROM_APPEND: assert property (@(posedge clk) disable iff (!rst_n)
        kpd_int_set |-> ($past(push_valid) && !$past(flush) && $past(len_o) != LFULL)); // R3

    AST_OVF_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovf_set |-> ($past(len_o) == LFULL && !$past(flush)
                          && !($past(err_ovf_bit) && $past(err_status_bit)))); // R4

    AST_LOCK_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && err_ovf_bit && err_status_bit && !pop_req && !flush)
        |=> ($stable(len_o) && !kpd_int_set && !fifo_ovf_set)); // R5

    AST_SHORT_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && !flush && !push_valid && len_o <= LEN_W'(1))
        |=> (pop_data == 8'h00 && $stable(len_o))); // R6

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (len_o == '0 && pop_data == 8'h00 && occ == OCC_EMPTY)); // R10

    AST_SWAP_KEEPS_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && pop_req && !flush && !(err_ovf_bit && err_status_bit)
         && len_o > LEN_W'(1) && len_o < LFULL) |=> $stable(len_o)); // R11

    AST_OCC_MATCHES_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((occ == OCC_EMPTY) == (len_o == '0)) && ((occ == OCC_SINGLE) == (len_o == LEN_W'(1)))
        && ((occ == OCC_FULL) == (len_o == LFULL))); // R9

endmodule

bind key_event_queue key_event_queue_chk #(.DEPTH(DEPTH)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .push_valid     (push_valid),
    .pop_req        (pop_req),
    .flush          (flush),
    .err_ovf_bit    (err_ovf_bit),
    .err_status_bit (err_status_bit),
    .pop_data       (pop_data),
    .len_o          (len_o),
    .kpd_int_set    (kpd_int_set),
    .fifo_ovf_set   (fifo_ovf_set),
    .occ            (u_ctrl.occ_q)
);

// File: tb/key_event_queue_test.sv
`timescale 1ns/100ps
module key_event_queue_test;

    typedef struct {
        logic [7:0] pop_byte;
        logic       chk_pop;
        logic       kpd;
        logic       ovf;
        int         len;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0, push_press = 1'b0, pop_req = 1'b0, flush = 1'b0;
    logic [6:0] push_code = '0;
    logic       err_ovf_bit = 1'b0, err_status_bit = 1'b0;
    logic [3:0] peek_idx = '0;
    logic [7:0] peek_data, pop_data;
    logic [4:0] len_o;
    logic       kpd_int_set, fifo_ovf_set;

    int   checks = 0, errors = 0;
    bit   done = 0;
    exp_t sb[$];

    logic [7:0] m_mem [16];
    int         m_start = 0, m_len = 0;

    always #2.5 clk = ~clk;

    key_event_queue uut (
        .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_code(push_code),
        .push_press(push_press), .pop_req(pop_req), .flush(flush),
        .err_ovf_bit(err_ovf_bit), .err_status_bit(err_status_bit),
        .peek_idx(peek_idx), .peek_data(peek_data), .pop_data(pop_data),
        .len_o(len_o), .kpd_int_set(kpd_int_set), .fifo_ovf_set(fifo_ovf_set)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus, expected results go to the scoreboard
    task automatic step(input bit psh, input logic [7:0] byt, input bit pop,
                        input bit fl, input bit eo, input bit es, input string tag);
        exp_t e;
        bit   lockm, acc;
        @(negedge clk);
        push_valid = psh; push_code = byt[6:0]; push_press = byt[7];
        pop_req = pop; flush = fl; err_ovf_bit = eo; err_status_bit = es;
        lockm = eo && es;
        acc   = psh && !fl && !lockm && m_len < 16;
        e.kpd = acc;
        e.ovf = psh && !fl && !lockm && m_len == 16;
        e.chk_pop = pop || fl;
        e.pop_byte = 8'h00;
        e.tag = tag;
        if (fl) begin
            m_start = 0; m_len = 0;
        end else begin
            if (acc) m_mem[(m_start + m_len) % 16] = byt;
            if (pop && m_len > 1) begin
                m_start = (m_start + 1) % 16;
                e.pop_byte = m_mem[m_start];
                m_len--;
            end
            if (acc) m_len++;
        end
        e.len = m_len;
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        push_valid = 0; pop_req = 0; flush = 0; err_ovf_bit = 0; err_status_bit = 0;
    endtask

    // Monitor: compare the design's results after each edge
    always @(posedge clk) begin
        if (rst_n && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            #2;
            if (e.chk_pop) check({e.tag, " R7 pop_data"}, pop_data, e.pop_byte);
            check({e.tag, " R3 kpd_int_set"}, kpd_int_set, e.kpd);
            check({e.tag, " R4 fifo_ovf_set"}, fifo_ovf_set, e.ovf);
            check({e.tag, " R2 len_o"}, len_o, e.len);
        end
    end

    // R8: every offset against the model, inputs idle
    task automatic peek_all(input string tag);
        idle();
        for (int i = 0; i < 16; i++) begin
            peek_idx = 4'(i);
            #0.1;
            check({tag, " R8 peek"}, peek_data,
                  (i < m_len) ? m_mem[(m_start + i) % 16] : 8'h00);
        end
        check({tag, " R8 peek keeps len"}, len_o, m_len);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 len", len_o, 0);
        check("R1 pop_data", pop_data, 0);
        check("R1 kpd", kpd_int_set, 0);
        check("R1 ovf", fifo_ovf_set, 0);
        rst_n = 1'b1;

        // R2/R3 ordering, R6 short reads
        step(0, 8'h00, 1, 0, 0, 0, "R6 pop empty");
        step(1, 8'hBC, 0, 0, 0, 0, "R2 press");
        step(0, 8'h00, 1, 0, 0, 0, "R6 pop single");
        step(1, 8'h3C, 0, 0, 0, 0, "R3 release");
        step(1, 8'h55, 0, 0, 0, 0, "R3 third");
        peek_all("R2 three held");
        step(0, 8'h00, 1, 0, 0, 0, "R7 pop1");
        step(0, 8'h00, 1, 0, 0, 0, "R7 pop2");
        step(0, 8'h00, 1, 0, 0, 0, "R6 pop one left");
        idle(); idle();
        check("R7 pop_data holds", pop_data, 8'h00);

        // R10 flush, storage kept but hidden
        step(0, 8'h00, 0, 1, 0, 0, "R10 flush");
        peek_all("R10 after flush");

        // R4 fill and overflow
        for (int i = 0; i < 16; i++) step(1, 8'(8'h10 + i), 0, 0, 0, 0, "R4 fill");
        step(1, 8'hEE, 0, 0, 0, 0, "R4 overflow");
        peek_all("R4 full");
        // R5 lock both / only one
        step(1, 8'hEF, 0, 0, 1, 1, "R5 locked full");
        step(1, 8'hEF, 0, 0, 1, 0, "R5 one bit full");
        // R11 read at full with append
        step(1, 8'hE1, 1, 0, 0, 0, "R11 full swap");
        step(1, 8'hE2, 0, 0, 0, 1, "R5 one bit append");
        step(1, 8'hE3, 1, 0, 1, 1, "R5 locked with pop");
        peek_all("R5 after lock");
        step(0, 8'h00, 0, 1, 0, 0, "R10 flush2");

        // R11 at length 1 and middle
        step(1, 8'h21, 0, 0, 0, 0, "R11 seed");
        step(1, 8'h22, 1, 0, 0, 0, "R11 len1 both");
        step(1, 8'h23, 0, 0, 0, 0, "R11 grow");
        step(1, 8'h24, 1, 0, 0, 0, "R11 mid swap");
        peek_all("R11 after swap");

        // R9 long wrap traffic
        for (int i = 0; i < 120; i++) begin
            step((i % 3) != 2, 8'((i * 37) & 8'hFF), (i % 4) != 0, 0, 0, 0, "R9 wrap");
        end
        peek_all("R9 wrapped");
        for (int i = 0; i < 20; i++) step(0, 8'h00, 1, 0, 0, 0, "R9 drain");
        peek_all("R9 drained");

        // R10 flush beats append and read
        step(1, 8'h41, 0, 0, 0, 0, "R10 pre");
        step(1, 8'h42, 0, 0, 0, 0, "R10 pre");
        step(1, 8'h43, 0, 0, 0, 0, "R10 pre");
        step(1, 8'h44, 1, 1, 0, 0, "R10 flush priority");
        peek_all("R10 priority");
        step(1, 8'h45, 0, 0, 0, 0, "R10 restart");
        peek_all("R10 restart");

        idle(); idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule